// File: doc/BRIEF.md
# Chunk-Level Sacrificial Line Merger

This block is the read and write steering layer of a cache that keeps working at very low supply voltage, where many SRAM cells fail. Lines are collected into groups whose members have no faulty chunk in a common position. One extra line per group, the sacrificial line, holds a spare copy of every chunk that some member cannot store reliably. On each access the block looks up the line's group and its slot in that group. It reads the data line and the group's sacrificial line from two separate banks in the same cycle. It then builds the logical line one chunk at a time, taking each chunk from whichever of the two physical lines holds the good copy.

Configuration ports fill the per-line map (disable flag, group, slot) and the per-group owner table after a fault scan. In high-voltage mode the lookup and sacrificial bank are held idle, and data passes straight between the request port and the data bank. Responses are registered and appear one cycle after the request.

Top module: `ftc_line_merger`

## Requirements
- R1: While `rst` is high and in the cycle after it, `rsp_valid`, `rsp_err` and `rsp_data` are all zero.
- R2: Each accepted request (`req_valid` high) gives exactly one `rsp_valid` pulse in the following cycle, and no response appears without a request.
- R3: In low-voltage mode (`hv_mode`=0), a read of an enabled line with slot s (1 to 2^SLOT_W-1) returns chunk i (bits i*CHUNK_W upward) from the group's sacrificial line when owner field i of the group's entry equals s. Otherwise chunk i comes from the data line.
- R4: A line whose map slot is 0 belongs to no group. In low-voltage mode its reads and writes use the data line only.
- R5: A low-voltage write to an enabled line stores the whole word in the data line. Every chunk that the line owns is also stored at the same position of its group's sacrificial line.
- R6: A write leaves untouched every sacrificial chunk that is owned by another member or by no member.
- R7: In low-voltage mode, an access to a line whose disable flag is set responds with `rsp_err`=1 and `rsp_data`=0, and does not change either bank.
- R8: In high-voltage mode the map is ignored. Reads return the data line unchanged, `rsp_err` stays 0 even for disabled lines, writes change only the data line, and the sacrificial bank sees no write.
- R9: A write response carries `rsp_data`=0.
- R10: A map or owner-table update written in one cycle governs requests issued in any later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hv_mode | input | 1 | 1 = high-voltage bypass, 0 = remapped low-voltage operation |
| req_valid | input | 1 | Request strobe |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (4) | Logical line index |
| req_wdata | input | LINE_W (32) | Write data |
| cfg_map_we | input | 1 | Write one line-map entry |
| cfg_map_line | input | AW (4) | Line whose entry is written |
| cfg_map_dis | input | 1 | Disable flag for that line |
| cfg_map_grp | input | GW (3) | Group of that line |
| cfg_map_slot | input | SLOT_W (2) | Slot within the group, 0 = no group |
| cfg_fm_we | input | 1 | Write one owner-table entry |
| cfg_fm_grp | input | GW (3) | Group whose owners are written |
| cfg_fm_own | input | NCHUNK*SLOT_W (8) | Owner slot per chunk position, field i at bits i*SLOT_W upward |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Access hit a disabled line |
| rsp_data | output | LINE_W (32) | Read data, zero for writes and errors |

## Verification
Every cycle, the assertions check the one-cycle response timing. They also check that error responses and write responses carry no data, that high-voltage requests never raise an error, and that the sacrificial bank is never written while it is gated off. Whether each chunk came from the right physical line can only be seen through the bench's scenarios. The same holds for whether a write spared the sacrificial chunks of other members, and whether a bypass write left the spare copies stale. Those scenarios write group members, read them back, and compare against a behavioural model of both banks and both maps.

// File: rtl/ftc_pkg.sv
package ftc_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } ftc_op_e;

  function automatic ftc_op_e decode_op(input logic valid, input logic we);
    if (!valid)  return OP_IDLE;
    else if (we) return OP_WRITE;
    else         return OP_READ;
  endfunction

endpackage

// File: rtl/ftc_map_store.sv
module ftc_map_store #(
  parameter int LINES  = 16,
  parameter int GROUPS = 8,
  parameter int NCHUNK = 4,
  parameter int SLOT_W = 2,
  localparam int AW    = $clog2(LINES),
  localparam int GW    = $clog2(GROUPS),
  localparam int OWN_W = NCHUNK * SLOT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_map_we,
  input  logic [AW-1:0]     cfg_map_line,
  input  logic              cfg_map_dis,
  input  logic [GW-1:0]     cfg_map_grp,
  input  logic [SLOT_W-1:0] cfg_map_slot,
  input  logic              cfg_fm_we,
  input  logic [GW-1:0]     cfg_fm_grp,
  input  logic [OWN_W-1:0]  cfg_fm_own,
  input  logic              lk_en,
  input  logic [AW-1:0]     lk_line,
  output logic              lk_dis,
  output logic [GW-1:0]     lk_grp,
  output logic [SLOT_W-1:0] lk_slot,
  output logic [OWN_W-1:0]  lk_own
);

  logic              map_dis  [LINES];
  logic [GW-1:0]     map_grp  [LINES];
  logic [SLOT_W-1:0] map_slot [LINES];
  logic [OWN_W-1:0]  fm_own   [GROUPS];

  // line map: one entry per logical line
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) begin
        map_dis[i]  <= 1'b0;
        map_grp[i]  <= '0;
        map_slot[i] <= '0;
      end
    end else if (cfg_map_we) begin
      map_dis[cfg_map_line]  <= cfg_map_dis;
      map_grp[cfg_map_line]  <= cfg_map_grp;
      map_slot[cfg_map_line] <= cfg_map_slot;
    end
  end

  // owner table: one entry per group, one owner field per chunk
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int g = 0; g < GROUPS; g++) fm_own[g] <= '0;
    end else if (cfg_fm_we) begin
      fm_own[cfg_fm_grp] <= cfg_fm_own;
    end
  end

  // lookup is held at zero while gated, so nothing downstream toggles
  logic [GW-1:0] grp_sel;
  assign grp_sel = map_grp[lk_line];

  always_comb begin
    lk_dis  = 1'b0;
    lk_grp  = '0;
    lk_slot = '0;
    lk_own  = '0;
    if (lk_en) begin
      lk_dis  = map_dis[lk_line];
      lk_grp  = grp_sel;
      lk_slot = map_slot[lk_line];
      lk_own  = fm_own[grp_sel];
    end
  end

  // R4: a gated lookup never reports group membership
  slot_gated_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_en |-> (lk_slot == '0 && lk_own == '0));

endmodule

// File: rtl/ftc_chunk_mux.sv
module ftc_chunk_mux #(
  parameter int NCHUNK  = 4,
  parameter int CHUNK_W = 8,
  parameter int SLOT_W  = 2,
  localparam int LINE_W = NCHUNK * CHUNK_W,
  localparam int OWN_W  = NCHUNK * SLOT_W
) (
  input  logic [SLOT_W-1:0] slot,
  input  logic [OWN_W-1:0]  own,
  input  logic [LINE_W-1:0] dline,
  input  logic [LINE_W-1:0] sline,
  output logic [LINE_W-1:0] rd_line,
  output logic [NCHUNK-1:0] sac_be
);

  logic member;
  assign member = (slot != '0);

  for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
    logic [SLOT_W-1:0] owner;
    logic              hit;
    assign owner = own[c*SLOT_W +: SLOT_W];
    assign hit   = member && (owner == slot);
    assign sac_be[c] = hit;
    assign rd_line[c*CHUNK_W +: CHUNK_W] =
      hit ? sline[c*CHUNK_W +: CHUNK_W] : dline[c*CHUNK_W +: CHUNK_W];
  end

endmodule

// File: rtl/ftc_line_banks.sv
module ftc_line_banks #(
  parameter int LINES   = 16,
  parameter int GROUPS  = 8,
  parameter int NCHUNK  = 4,
  parameter int CHUNK_W = 8,
  localparam int AW     = $clog2(LINES),
  localparam int GW     = $clog2(GROUPS),
  localparam int LINE_W = NCHUNK * CHUNK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              d_we,
  input  logic [AW-1:0]     d_addr,
  input  logic [LINE_W-1:0] d_wdata,
  output logic [LINE_W-1:0] d_rdata,
  input  logic              s_en,
  input  logic [NCHUNK-1:0] s_be,
  input  logic [GW-1:0]     s_addr,
  input  logic [LINE_W-1:0] s_wdata,
  output logic [LINE_W-1:0] s_rdata
);

  logic [LINE_W-1:0] d_mem [LINES];
  logic [LINE_W-1:0] s_mem [GROUPS];

  initial begin
    for (int i = 0; i < LINES; i++)  d_mem[i] = '0;
    for (int g = 0; g < GROUPS; g++) s_mem[g] = '0;
  end

  // data bank: full-line writes
  always_ff @(posedge clk) begin
    if (d_we) d_mem[d_addr] <= d_wdata;
  end

  // sacrificial bank: per-chunk enables, only while its clock enable is on
  always_ff @(posedge clk) begin
    if (s_en) begin
      for (int c = 0; c < NCHUNK; c++) begin
        if (s_be[c]) s_mem[s_addr][c*CHUNK_W +: CHUNK_W] <= s_wdata[c*CHUNK_W +: CHUNK_W];
      end
    end
  end

  assign d_rdata = d_mem[d_addr];
  assign s_rdata = s_en ? s_mem[s_addr] : '0;

  // R8: chunk enables toward a gated sacrificial bank must be silent
  sac_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (s_be != '0) |-> s_en);

endmodule

// File: rtl/ftc_line_merger.sv
module ftc_line_merger #(
  parameter int LINES   = 16,
  parameter int GROUPS  = 8,
  parameter int NCHUNK  = 4,
  parameter int CHUNK_W = 8,
  parameter int SLOT_W  = 2,
  localparam int AW     = $clog2(LINES),
  localparam int GW     = $clog2(GROUPS),
  localparam int LINE_W = NCHUNK * CHUNK_W,
  localparam int OWN_W  = NCHUNK * SLOT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hv_mode,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [AW-1:0]     req_addr,
  input  logic [LINE_W-1:0] req_wdata,
  input  logic              cfg_map_we,
  input  logic [AW-1:0]     cfg_map_line,
  input  logic              cfg_map_dis,
  input  logic [GW-1:0]     cfg_map_grp,
  input  logic [SLOT_W-1:0] cfg_map_slot,
  input  logic              cfg_fm_we,
  input  logic [GW-1:0]     cfg_fm_grp,
  input  logic [OWN_W-1:0]  cfg_fm_own,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [LINE_W-1:0] rsp_data
);

  import ftc_pkg::*;

  ftc_op_e op;
  assign op = decode_op(req_valid, req_we);

  logic lv_access;
  assign lv_access = req_valid && !hv_mode;

  logic              lk_dis;
  logic [GW-1:0]     lk_grp;
  logic [SLOT_W-1:0] lk_slot;
  logic [OWN_W-1:0]  lk_own;

  ftc_map_store #(
    .LINES(LINES), .GROUPS(GROUPS), .NCHUNK(NCHUNK), .SLOT_W(SLOT_W)
  ) u_map (
    .clk(clk), .rst(rst),
    .cfg_map_we(cfg_map_we), .cfg_map_line(cfg_map_line), .cfg_map_dis(cfg_map_dis),
    .cfg_map_grp(cfg_map_grp), .cfg_map_slot(cfg_map_slot),
    .cfg_fm_we(cfg_fm_we), .cfg_fm_grp(cfg_fm_grp), .cfg_fm_own(cfg_fm_own),
    .lk_en(lv_access), .lk_line(req_addr),
    .lk_dis(lk_dis), .lk_grp(lk_grp), .lk_slot(lk_slot), .lk_own(lk_own)
  );

  logic blocked;
  assign blocked = lv_access && lk_dis;

  logic [LINE_W-1:0] d_rdata, s_rdata, merged;
  logic [NCHUNK-1:0] own_be, s_be;

  ftc_chunk_mux #(
    .NCHUNK(NCHUNK), .CHUNK_W(CHUNK_W), .SLOT_W(SLOT_W)
  ) u_mux (
    .slot(lk_slot), .own(lk_own), .dline(d_rdata), .sline(s_rdata),
    .rd_line(merged), .sac_be(own_be)
  );

  logic d_we;
  assign d_we = (op == OP_WRITE) && !blocked;
  assign s_be = ((op == OP_WRITE) && lv_access && !blocked) ? own_be : '0;

  ftc_line_banks #(
    .LINES(LINES), .GROUPS(GROUPS), .NCHUNK(NCHUNK), .CHUNK_W(CHUNK_W)
  ) u_banks (
    .clk(clk), .rst(rst),
    .d_we(d_we), .d_addr(req_addr), .d_wdata(req_wdata), .d_rdata(d_rdata),
    .s_en(lv_access), .s_be(s_be), .s_addr(lk_grp), .s_wdata(req_wdata),
    .s_rdata(s_rdata)
  );

  // single registered response stage
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= (op != OP_IDLE);
      rsp_err   <= blocked;
      if (op == OP_READ && !blocked) rsp_data <= hv_mode ? d_rdata : merged;
      else                           rsp_data <= '0;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!rsp_valid && !rsp_err && rsp_data == '0));

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  // R2
  rsp_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  // R7
  err_no_data_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_valid && rsp_data == '0));

  // R8
  hv_no_err_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && hv_mode) |=> !rsp_err);

  // R9
  wr_rsp_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_we) |=> (rsp_data == '0));

endmodule

// File: tb/ftc_line_merger_tb.sv
module ftc_line_merger_tb;

  localparam int LINES = 16, GROUPS = 8, NCHUNK = 4, CHUNK_W = 8, SLOT_W = 2;
  localparam int AW = 4, GW = 3, LINE_W = 32, OWN_W = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst = 1'b1, hv_mode = 1'b0;
  logic              req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0]     req_addr = '0;
  logic [LINE_W-1:0] req_wdata = '0;
  logic              cfg_map_we = 1'b0, cfg_map_dis = 1'b0;
  logic [AW-1:0]     cfg_map_line = '0;
  logic [GW-1:0]     cfg_map_grp = '0;
  logic [SLOT_W-1:0] cfg_map_slot = '0;
  logic              cfg_fm_we = 1'b0;
  logic [GW-1:0]     cfg_fm_grp = '0;
  logic [OWN_W-1:0]  cfg_fm_own = '0;
  logic              rsp_valid, rsp_err;
  logic [LINE_W-1:0] rsp_data;

  ftc_line_merger u_dut (
    .clk(clk), .rst(rst), .hv_mode(hv_mode),
    .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .cfg_map_we(cfg_map_we), .cfg_map_line(cfg_map_line), .cfg_map_dis(cfg_map_dis),
    .cfg_map_grp(cfg_map_grp), .cfg_map_slot(cfg_map_slot),
    .cfg_fm_we(cfg_fm_we), .cfg_fm_grp(cfg_fm_grp), .cfg_fm_own(cfg_fm_own),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data)
  );

  // behavioural model state
  bit          m_dis  [LINES];
  int          m_grp  [LINES];
  int          m_slot [LINES];
  int          m_own  [GROUPS][NCHUNK];
  logic [31:0] m_data [LINES];
  logic [31:0] m_sac  [GROUPS];

  int n_chk = 0, n_err = 0;
  bit          exp_valid = 1'b0, exp_err = 1'b0;
  logic [31:0] exp_data = '0;
  string       exp_tag = "R2";
  string       tag_override = "";

  task automatic fail(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_err++;
    $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
  endtask

  // compares the response to the request of the previous cycle
  task automatic check_prev();
    n_chk++;
    if (rsp_valid !== exp_valid) fail("R2", "rsp_valid", 32'(rsp_valid), 32'(exp_valid));
    if (exp_valid) begin
      n_chk++;
      if (rsp_err !== exp_err) fail(exp_tag, "rsp_err", 32'(rsp_err), 32'(exp_err));
      n_chk++;
      if (rsp_data !== exp_data) fail(exp_tag, "rsp_data", rsp_data, exp_data);
    end
  endtask

  task automatic clear_inputs();
    req_valid = 1'b0; req_we = 1'b0; cfg_map_we = 1'b0; cfg_fm_we = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
    check_prev();
    clear_inputs();
    exp_valid = 1'b0;
  endtask

  task automatic set_map(int line, bit dis, int grp, int slot);
    @(negedge clk);
    check_prev();
    clear_inputs();
    exp_valid = 1'b0;
    cfg_map_we = 1'b1; cfg_map_line = AW'(line); cfg_map_dis = dis;
    cfg_map_grp = GW'(grp); cfg_map_slot = SLOT_W'(slot);
    m_dis[line] = dis; m_grp[line] = grp; m_slot[line] = slot;
  endtask

  task automatic set_owners(int grp, int o0, int o1, int o2, int o3);
    @(negedge clk);
    check_prev();
    clear_inputs();
    exp_valid = 1'b0;
    cfg_fm_we = 1'b1; cfg_fm_grp = GW'(grp);
    cfg_fm_own = {SLOT_W'(o3), SLOT_W'(o2), SLOT_W'(o1), SLOT_W'(o0)};
    m_own[grp][0] = o0; m_own[grp][1] = o1; m_own[grp][2] = o2; m_own[grp][3] = o3;
  endtask

  // issues one request and computes its expected response from the model
  task automatic access(bit we, int a, logic [31:0] wd, bit hv);
    int g, s;
    @(negedge clk);
    check_prev();
    clear_inputs();
    g = m_grp[a]; s = m_slot[a];
    exp_valid = 1'b1; exp_err = 1'b0; exp_data = '0;
    if (hv) begin
      exp_tag = "R8";
      if (we) m_data[a] = wd;
      else    exp_data = m_data[a];
    end else if (m_dis[a]) begin
      exp_tag = "R7";
      exp_err = 1'b1;
    end else if (we) begin
      exp_tag = "R9";
      m_data[a] = wd;
      for (int c = 0; c < NCHUNK; c++)
        if (s != 0 && m_own[g][c] == s) m_sac[g][c*8 +: 8] = wd[c*8 +: 8];
    end else begin
      exp_tag = (s == 0) ? "R4" : "R3";
      for (int c = 0; c < NCHUNK; c++)
        exp_data[c*8 +: 8] = (s != 0 && m_own[g][c] == s) ? m_sac[g][c*8 +: 8]
                                                           : m_data[a][c*8 +: 8];
    end
    if (tag_override != "") exp_tag = tag_override;
    req_valid = 1'b1; req_we = we; req_addr = AW'(a); req_wdata = wd; hv_mode = hv;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < LINES; i++) begin
      m_dis[i] = 1'b0; m_grp[i] = 0; m_slot[i] = 0; m_data[i] = '0;
    end
    for (int g = 0; g < GROUPS; g++) begin
      m_sac[g] = '0;
      for (int c = 0; c < NCHUNK; c++) m_own[g][c] = 0;
    end

    // R1: quiet outputs during reset
    repeat (3) @(negedge clk);
    n_chk++;
    if (rsp_valid !== 1'b0 || rsp_err !== 1'b0 || rsp_data !== '0)
      fail("R1", "reset outputs", {rsp_valid, rsp_err, rsp_data[29:0]}, 32'h0);
    rst = 1'b0;
    idle();

    // group 2: lines 4,10,15 ; group 1: lines 1,9 ; line 7 disabled
    set_map(4, 0, 2, 1);  set_map(10, 0, 2, 2); set_map(15, 0, 2, 3);
    set_map(1, 0, 1, 1);  set_map(9, 0, 1, 2);  set_map(7, 1, 3, 0);
    set_owners(2, 1, 2, 0, 3);
    set_owners(1, 2, 1, 1, 0);

    // R8: bypass fill and readback, disabled line readable in bypass
    for (int i = 0; i < LINES; i++) access(1, i, 32'hA000_0000 + i * 32'h0101_0101, 1);
    for (int i = 0; i < LINES; i++) access(0, i, '0, 1);

    // R5: low-voltage writes place owned chunks into the sacrificial line
    access(1, 4,  32'h11223344, 0);
    access(1, 10, 32'h55667788, 0);
    access(1, 15, 32'h99AABBCC, 0);
    access(1, 1,  32'hDEADBEEF, 0);
    access(1, 9,  32'hCAFEF00D, 0);
    // R3: merged reads of each member
    access(0, 4, '0, 0); access(0, 10, '0, 0); access(0, 15, '0, 0);
    access(0, 1, '0, 0); access(0, 9, '0, 0);
    // R4: ungrouped line
    access(1, 3, 32'h0BADC0DE, 0);
    access(0, 3, '0, 0);
    // R6: rewrite one member, others keep their spare chunks
    access(1, 10, 32'h01020304, 0);
    tag_override = "R6";
    access(0, 4, '0, 0); access(0, 15, '0, 0);
    tag_override = "";
    // R7: disabled line, then check it stayed unchanged through bypass
    access(1, 7, 32'hFFFF0000, 0);
    access(0, 7, '0, 0);
    tag_override = "R7";
    access(0, 7, '0, 1);
    tag_override = "";
    // R8: bypass write leaves the spare copies stale
    access(1, 4, 32'h77777777, 1);
    tag_override = "R8";
    access(0, 4, '0, 0);
    tag_override = "";
    // R10: owner change applies to the next request
    set_owners(2, 3, 3, 2, 1);
    tag_override = "R10";
    access(0, 15, '0, 0);
    access(1, 15, 32'h13579BDF, 0);
    access(0, 15, '0, 0); access(0, 4, '0, 0);
    set_map(3, 0, 2, 2);
    access(0, 3, '0, 0);
    tag_override = "";
    // R2: idle gap
    idle(); idle();

    // mixed traffic
    for (int k = 0; k < 400; k++) begin
      int r;
      r = int'($urandom_range(0, 19));
      if (r == 0)
        set_owners(int'($urandom_range(0, 7)), int'($urandom_range(0, 3)),
                   int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                   int'($urandom_range(0, 3)));
      else if (r == 1) idle();
      else access(bit'($urandom_range(0, 1)), int'($urandom_range(0, 15)),
                  $urandom, ($urandom_range(0, 3) == 0));
    end
    idle(); idle();

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule